// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block converts the addressing part of an interrupt message into the set of cores that must receive it. A request carries a destination byte, a bit that picks physical or logical addressing, a two-bit shorthand code, a lowest-priority flag and the sender's own core index. Alongside the request, the block reads each core's logical address byte, its addressing-model nibble and a vector of present cores. It returns a bitmask with one bit per core index. For lowest-priority messages it also returns a one-hot pick.

Requests enter through a valid/ready handshake, and results leave through one. The request side is ready whenever the output register is empty or is being drained in the same cycle. A result stays on the output pins, unchanged, until the consumer raises `res_ready`. While the output holds an unaccepted result, requests are refused, and the sender must keep its request asserted.

Logical matching is decided for each core on its own. A core whose model nibble is all ones uses flat matching, a core whose nibble is zero uses cluster matching, and any other nibble never matches. When the mask comes out empty, the block raises a no-target flag in place of a delivery.

Top module: `irq_dest_resolver`

## Requirements
- R1: With `req_shorthand`=0 and `req_logical`=0, a destination of 0xFF sets the bit of every present core.
- R2: With `req_shorthand`=0 and `req_logical`=0, any destination other than 0xFF sets only bit `req_dest`, if that core is present.
- R3: With `req_shorthand`=0 and `req_logical`=1, a core whose model nibble is 0xF is selected when `req_dest` AND its logical byte is nonzero.
- R4: With `req_shorthand`=0 and `req_logical`=1, a core whose model nibble is 0x0 is selected when `req_dest[7:4]` equals its logical byte's `[7:4]` and the two `[3:0]` nibbles share at least one set bit.
- R5: In logical mode, a core whose model nibble is neither 0xF nor 0x0 is never selected.
- R6: Shorthand code 1 selects only core `req_self_id`, if present, and ignores `req_dest` and `req_logical`.
- R7: Shorthand code 2 selects every present core. Shorthand code 3 selects every present core except `req_self_id`.
- R8: A bit whose `core_present` bit is 0 is never set in `res_mask` or `res_pick`.
- R9: With `req_lowpri`=1, `res_pick` holds only the lowest-numbered set bit of `res_mask`. With `req_lowpri`=0, `res_pick` is zero. `res_mask` carries the full set in both cases.
- R10: `res_none` is 1 exactly when `res_mask` is empty, and `res_pick` is then zero.
- R11: A request accepted at a clock edge (`req_valid` and `req_ready` both high) gives `res_valid`=1 with its result right after that edge. `req_ready` equals `!res_valid || res_ready`, and a result with `res_ready`=1 and no new request clears `res_valid` at the next edge.
- R12: While `res_valid`=1 and `res_ready`=0, the outputs hold their values and an offered request is not taken.
- R13: After reset, `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_shorthand | input | 2 | 0 dest field, 1 self, 2 all, 3 all but self |
| req_lowpri | input | 1 | Lowest-priority delivery requested |
| req_self_id | input | 8 | Index of the sending core |
| core_present | input | 256 | One bit per present core |
| core_ldr | input | 2048 | Logical byte of core i at [8i+7:8i] |
| core_model | input | 1024 | Model nibble of core i at [4i+3:4i] |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_mask | output | 256 | Resolved target bitmask |
| res_pick | output | 256 | One-hot lowest-priority choice, else zero |
| res_none | output | 1 | Resolved mask is empty |

## Verification
The assertions assume that `core_present`, `core_ldr` and `core_model` are stable configuration that does not change between the acceptance of a request and the consumption of its result. They also assume that a consumer which is not ready leaves `res_ready` low rather than toggling it mid-cycle. The stimulus changes the core tables only while the output register is empty. It drives every input half a period away from the sampling edge and holds `res_ready` low while it reads a result, so every check sees a stalled, stable output.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
endpackage

// File: rtl/irq_core_match.sv
module irq_core_match
  import irq_dest_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int MODEL_W = 4,
  parameter int IDX     = 0
) (
  input  logic [ID_W-1:0]    dest,
  input  logic               logical,
  input  shorthand_e         shorthand,
  input  logic [ID_W-1:0]    self_id,
  input  logic               present,
  input  logic [ID_W-1:0]    ldr,
  input  logic [MODEL_W-1:0] model,
  output logic               hit
);
  localparam int HALF = ID_W / 2;
  localparam logic [ID_W-1:0] MY_ID = ID_W'(IDX);

  logic phys_hit, flat_hit, clus_hit, field_hit, is_self;

  assign is_self   = (self_id == MY_ID);
  assign phys_hit  = (dest == {ID_W{1'b1}}) || (dest == MY_ID);
  assign flat_hit  = (model == MODEL_FLAT) && (|(dest & ldr));
  assign clus_hit  = (model == MODEL_CLUSTER)
                   && (dest[ID_W-1:HALF] == ldr[ID_W-1:HALF])
                   && (|(dest[HALF-1:0] & ldr[HALF-1:0]));
  assign field_hit = logical ? (flat_hit || clus_hit) : phys_hit;

  always_comb begin
    unique case (shorthand)
      SH_FIELD:  hit = field_hit;
      SH_SELF:   hit = is_self;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_self;
      default:   hit = 1'b0;
    endcase
    hit = hit && present;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int W = 256
) (
  input  logic [W-1:0] mask,
  output logic [W-1:0] pick,
  output logic         empty
);
  assign pick  = mask & (~mask + W'(1));
  assign empty = (mask == '0);
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int MODEL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ID_W-1:0]               req_dest,
  input  logic                          req_logical,
  input  logic [1:0]                    req_shorthand,
  input  logic                          req_lowpri,
  input  logic [ID_W-1:0]               req_self_id,
  input  logic [(1<<ID_W)-1:0]          core_present,
  input  logic [(1<<ID_W)*ID_W-1:0]     core_ldr,
  input  logic [(1<<ID_W)*MODEL_W-1:0]  core_model,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic [(1<<ID_W)-1:0]          res_mask,
  output logic [(1<<ID_W)-1:0]          res_pick,
  output logic                          res_none
);
  localparam int NCORE = 1 << ID_W;

  shorthand_e       sh;
  logic [NCORE-1:0] hits, lowest;
  logic             empty, accept;

  assign sh        = shorthand_e'(req_shorthand);
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    irq_core_match #(.ID_W(ID_W), .MODEL_W(MODEL_W), .IDX(i)) u_match (
      .dest      (req_dest),
      .logical   (req_logical),
      .shorthand (sh),
      .self_id   (req_self_id),
      .present   (core_present[i]),
      .ldr       (core_ldr[i*ID_W +: ID_W]),
      .model     (core_model[i*MODEL_W +: MODEL_W]),
      .hit       (hits[i])
    );
  end

  irq_lowest_pick #(.W(NCORE)) u_pick (
    .mask  (hits),
    .pick  (lowest),
    .empty (empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_mask  <= '0;
      res_pick  <= '0;
      res_none  <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_mask  <= hits;
      res_pick  <= req_lowpri ? lowest : '0;
      res_none  <= empty;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R9
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_pick));

  // R9
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pick != '0) |-> (((res_pick - NCORE'(1)) & res_mask) == '0)
                                      && ((res_pick & res_mask) != '0));

  // R10
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_none) |-> (res_mask == '0 && res_pick == '0));

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_mask)
                                  && $stable(res_pick) && $stable(res_none));
endmodule

// File: tb/tb_irq_dest_resolver.sv
module tb_irq_dest_resolver;
  localparam int N = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_dest = '0, req_self_id = '0;
  logic req_logical = 1'b0, req_lowpri = 1'b0;
  logic [1:0] req_shorthand = '0;
  logic [N-1:0] core_present = '0;
  logic [N*8-1:0] core_ldr = '0;
  logic [N*4-1:0] core_model = '0;
  logic res_valid, res_ready = 1'b0, res_none;
  logic [N-1:0] res_mask, res_pick;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_dest_resolver dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical), .req_shorthand(req_shorthand),
    .req_lowpri(req_lowpri), .req_self_id(req_self_id), .core_present(core_present),
    .core_ldr(core_ldr), .core_model(core_model), .res_valid(res_valid),
    .res_ready(res_ready), .res_mask(res_mask), .res_pick(res_pick), .res_none(res_none)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                      input logic lp, input logic [7:0] sid);
    @(negedge clk);
    req_dest = d; req_logical = lg; req_shorthand = sh; req_lowpri = lp;
    req_self_id = sid; req_valid = 1'b1; res_ready = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); res_ready = 1'b1;
    @(posedge clk); #1; res_ready = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [N-1:0] m, input logic [N-1:0] p);
    chk({req, " valid"}, N'(res_valid), N'(1));
    chk({req, " mask"}, res_mask, m);
    chk({req, " pick"}, res_pick, p);
    chk({req, " none"}, N'(res_none), N'(m == '0));
    drain();
  endtask

  task automatic clear_tables();
    core_present = '1; core_ldr = '0; core_model = '0;
  endtask

  task automatic t_reset();
    chk("R13 res_valid", N'(res_valid), N'(0));
    chk("R13 req_ready", N'(req_ready), N'(1));
  endtask

  task automatic t_physical();
    logic [N-1:0] all_but7;
    clear_tables();
    send(8'd5, 1'b0, 2'd0, 1'b0, 8'd0);
    expect_res("R2 dest5", N'(1) << 5, '0);
    send(8'd200, 1'b0, 2'd0, 1'b0, 8'd0);
    expect_res("R2 dest200", N'(1) << 200, '0);
    core_present[7] = 1'b0;
    all_but7 = '1; all_but7[7] = 1'b0;
    send(8'hFF, 1'b0, 2'd0, 1'b0, 8'd0);
    expect_res("R1 broadcast", all_but7, '0);
    send(8'd7, 1'b0, 2'd0, 1'b0, 8'd0);
    expect_res("R8 R10 absent dest", '0, '0);
  endtask

  task automatic t_flat();
    clear_tables();
    for (int i = 0; i < 8; i++) begin
      core_model[i*4 +: 4] = 4'hF;
      core_ldr[i*8 +: 8] = 8'(1 << i);
    end
    for (int i = 8; i < N; i++) core_model[i*4 +: 4] = 4'hF;
    send(8'h24, 1'b1, 2'd0, 1'b0, 8'd0);
    expect_res("R3 flat 0x24", (N'(1) << 2) | (N'(1) << 5), '0);
    core_present[5] = 1'b0;
    send(8'h24, 1'b1, 2'd0, 1'b0, 8'd0);
    expect_res("R3 R8 flat absent", N'(1) << 2, '0);
  endtask

  task automatic t_cluster();
    clear_tables();
    core_ldr[10*8 +: 8] = 8'h31;
    core_ldr[11*8 +: 8] = 8'h32;
    core_ldr[12*8 +: 8] = 8'h41;
    core_ldr[13*8 +: 8] = 8'h33;
    send(8'h31, 1'b1, 2'd0, 1'b0, 8'd0);
    expect_res("R4 cluster 0x31", (N'(1) << 10) | (N'(1) << 13), '0);
    send(8'h34, 1'b1, 2'd0, 1'b0, 8'd0);
    expect_res("R4 cluster 0x34", '0, '0);
    core_model[13*4 +: 4] = 4'hF;
    send(8'h42, 1'b1, 2'd0, 1'b0, 8'd0);
    expect_res("R3 R4 mixed 0x42", N'(1) << 13, '0);
  endtask

  task automatic t_bad_model();
    clear_tables();
    for (int i = 0; i < N; i++) core_model[i*4 +: 4] = 4'h5;
    core_ldr[20*8 +: 8] = 8'hFF;
    core_ldr[21*8 +: 8] = 8'h80;
    core_model[21*4 +: 4] = 4'hF;
    send(8'hFF, 1'b1, 2'd0, 1'b0, 8'd0);
    expect_res("R5 other model", N'(1) << 21, '0);
  endtask

  task automatic t_shorthand();
    logic [N-1:0] all_m, others_m;
    clear_tables();
    core_present[100] = 1'b0;
    all_m = '1; all_m[100] = 1'b0;
    others_m = all_m; others_m[9] = 1'b0;
    send(8'd3, 1'b0, 2'd1, 1'b0, 8'd9);
    expect_res("R6 self", N'(1) << 9, '0);
    send(8'd3, 1'b1, 2'd2, 1'b0, 8'd9);
    expect_res("R7 all", all_m, '0);
    send(8'hFF, 1'b0, 2'd3, 1'b0, 8'd9);
    expect_res("R7 others", others_m, '0);
    send(8'd9, 1'b0, 2'd1, 1'b0, 8'd100);
    expect_res("R6 R8 absent self", '0, '0);
  endtask

  task automatic t_lowpri();
    logic [N-1:0] m;
    clear_tables();
    core_present[2:0] = 3'b000;
    m = '1; m[2:0] = 3'b000;
    send(8'hFF, 1'b0, 2'd0, 1'b1, 8'd0);
    expect_res("R9 lowpri broadcast", m, N'(1) << 3);
    send(8'hFF, 1'b0, 2'd0, 1'b0, 8'd0);
    expect_res("R9 no lowpri", m, '0);
    send(8'd1, 1'b0, 2'd0, 1'b1, 8'd0);
    expect_res("R10 lowpri empty", '0, '0);
  endtask

  task automatic t_flow();
    clear_tables();
    send(8'd1, 1'b0, 2'd0, 1'b0, 8'd0);
    @(negedge clk);
    req_dest = 8'd2; req_valid = 1'b1;
    chk("R11 ready low when full", N'(req_ready), N'(0));
    @(posedge clk); #1; req_valid = 1'b0;
    chk("R12 held mask", res_mask, N'(1) << 1);
    @(negedge clk);
    res_ready = 1'b1; req_dest = 8'd3; req_valid = 1'b1;
    #1 chk("R11 ready with drain", N'(req_ready), N'(1));
    @(posedge clk); #1; req_valid = 1'b0; res_ready = 1'b0;
    chk("R11 back-to-back valid", N'(res_valid), N'(1));
    chk("R11 back-to-back mask", res_mask, N'(1) << 3);
    drain();
    chk("R11 cleared", N'(res_valid), N'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_physical();
    t_flat();
    t_cluster();
    t_bad_model();
    t_shorthand();
    t_lowpri();
    t_flow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule